// File: doc/BRIEF.md
# Receive Frame Buffer Event Manager

This block sits between a host serial link receiver and a word-wide receive buffer. It takes one byte per cycle and packs the bytes of a frame into little-endian words. Each full word goes out on a simple valid/address/data write port, with addresses counted from zero within the frame. A lone end-of-frame strobe closes the frame and flushes any partly filled word. At the close, the block checks the received byte count against the length field of the frame header and decides whether the buffer may be handed on as data-ready.

Four sticky event flags record what happened:

- the end of a good reception;
- a programmable mid-frame waterlevel;
- a frame that ended short of its header length (underflow);
- bytes that kept arriving after a good CRC had been signalled (overflow).

Firmware clears each flag with its own one-cycle pulse. A per-flag enable mask folds the flags into one interrupt line. A mode input selects framed operation or native operation. Native operation has no header-length check.

Top module: `rxfrm_evt_mgr`

## Requirements
- R1: Byte k of a frame (k counted from 0) goes to lane k mod WORD_BYTES of word k / WORD_BYTES, at bits [8*lane+7:8*lane]. A full word appears on the write port one cycle after the byte that fills its top lane, and the address starts at 0 for every frame.
- R2: The cycle after an end-of-frame strobe, a partly filled last word is written at the next word address, with unused lanes zero. If the last word was already full, no write occurs.
- R3: Flag bit 0 (end of reception) sets in the cycle after the end-of-frame strobe, the same cycle as any flush write, unless that frame underflowed.
- R4: With a non-zero waterlevel setting, flag bit 1 sets one cycle after the accepted byte whose count within the frame equals the setting. A setting of 0 never sets it, and bit 0 still sets at the end of the frame.
- R5: In framed mode (native_mode=0), an end of frame with fewer accepted bytes than hdr_len sets flag bit 2, leaves bit 0 clear and does not raise buf_ready.
- R6: In native mode (native_mode=1), flag bit 2 never sets, and a short frame ends like a good one.
- R7: A byte that arrives in any cycle after the one in which crc_good was high within the frame sets flag bit 3. That byte is not written to the buffer, and buf_ready stays low at the end of the frame. Bit 3 stays set until its clear pulse.
- R8: buf_ready rises the cycle after the end of a frame with neither underflow nor overflow. It stays high until the first byte of the next frame, which drops it one cycle later.
- R9: Each flag is sticky. A pulse on flg_clr[i] clears flag i one cycle later, and a set event in the same cycle as the clear leaves the flag set.
- R10: irq is high exactly when some flag bit is set and the matching flg_en bit is high.
- R11: After reset, flags, buf_ready, irq and wr_vld are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | A received byte is present (never with frm_end) |
| byte_dat | input | 8 | Received byte |
| frm_end | input | 1 | End-of-frame strobe |
| crc_good | input | 1 | Correct CRC detected for the current frame |
| hdr_len | input | LEN_W | Frame length from the data-link header |
| native_mode | input | 1 | 1 disables the header-length check |
| wl_thresh | input | LEN_W | Waterlevel byte count, 0 disables |
| flg_clr | input | 4 | Per-flag clear pulses |
| flg_en | input | 4 | Per-flag interrupt enables |
| wr_vld | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer word address |
| wr_data | output | 8*WORD_BYTES | Buffer write word |
| flg_status | output | 4 | Sticky flags: 0 end, 1 waterlevel, 2 underflow, 3 overflow |
| buf_ready | output | 1 | Buffer holds a good frame |
| irq | output | 1 | Masked OR of the flags |

## Verification
The bench uses the default four-byte word, a 6-bit word address and an 8-bit length. With these values, frames of 1 to 9 bytes cover:

- every fill level of the final word;
- frames that end exactly on a word boundary;
- a frame that spills into a third word.

Header lengths one below, equal to and two above the frame length are swept in both modes. Waterlevel settings of 0, 1, the frame length and one past it are combined with frames that either stop at the CRC or carry two excess bytes. This drives every mix of the underflow, overflow and waterlevel outcomes.

// File: rtl/rxfrm_pkg.sv
package rxfrm_pkg;
    localparam int NFLAG   = 4;
    localparam int FLG_EOR = 0;
    localparam int FLG_WL  = 1;
    localparam int FLG_UF  = 2;
    localparam int FLG_OVF = 3;
endpackage

// File: rtl/rxfrm_packer.sv
module rxfrm_packer #(
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic                    first,
    input  logic [7:0]              dat,
    input  logic                    flush,
    output logic                    wr_vld,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [8*WORD_BYTES-1:0] wr_data
);
    localparam int LANE_W = $clog2(WORD_BYTES);
    localparam int DW     = 8 * WORD_BYTES;
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(WORD_BYTES - 1);

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [ADDR_W-1:0] widx;
        logic [DW-1:0]     acc;
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        logic [LANE_W-1:0] lane_c;
        logic [ADDR_W-1:0] widx_c;
        logic [DW-1:0]     acc_c;
        pk_d     = pk_q;
        pk_d.vld = 1'b0;
        lane_c   = first ? '0 : pk_q.lane;
        widx_c   = first ? '0 : pk_q.widx;
        acc_c    = first ? '0 : pk_q.acc;
        if (push) begin
            acc_c[8*lane_c +: 8] = dat;
            if (lane_c == TOP_LANE) begin
                pk_d.vld  = 1'b1;
                pk_d.addr = widx_c;
                pk_d.data = acc_c;
                pk_d.acc  = '0;
                pk_d.lane = '0;
                pk_d.widx = widx_c + 1'b1;
            end else begin
                pk_d.acc  = acc_c;
                pk_d.lane = lane_c + 1'b1;
                pk_d.widx = widx_c;
            end
        end else if (flush) begin
            if (pk_q.lane != '0) begin
                pk_d.vld  = 1'b1;
                pk_d.addr = pk_q.widx;
                pk_d.data = pk_q.acc;
            end
            pk_d.acc  = '0;
            pk_d.lane = '0;
            pk_d.widx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign wr_vld  = pk_q.vld;
    assign wr_addr = pk_q.addr;
    assign wr_data = pk_q.data;

    assert_flush_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !push && pk_q.lane != '0) |=> wr_vld);

    assert_write_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> $past(push || flush));
endmodule

// File: rtl/rxfrm_flags.sv
module rxfrm_flags #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] status,
    output logic          irq
);
    logic [NF-1:0] flg_d, flg_q;

    always_comb flg_d = (flg_q & ~clr) | set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign status = flg_q;
    assign irq    = |(flg_q & en);

    for (genvar i = 0; i < NF; i++) begin : g_chk
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> status[i]);
        assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !status[i]);
    end
endmodule

// File: rtl/rxfrm_evt_mgr.sv
module rxfrm_evt_mgr
    import rxfrm_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 6,
    parameter int LEN_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_dat,
    input  logic                    frm_end,
    input  logic                    crc_good,
    input  logic [LEN_W-1:0]        hdr_len,
    input  logic                    native_mode,
    input  logic [LEN_W-1:0]        wl_thresh,
    input  logic [3:0]              flg_clr,
    input  logic [3:0]              flg_en,
    output logic                    wr_vld,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [8*WORD_BYTES-1:0] wr_data,
    output logic [3:0]              flg_status,
    output logic                    buf_ready,
    output logic                    irq
);
    localparam int CW = LEN_W + 1;

    typedef struct packed {
        logic          in_frm;
        logic          crc_seen;
        logic          ovf_frm;
        logic [CW-1:0] cnt;
        logic          rdy;
    } fs_t;

    fs_t fs_d, fs_q;
    logic [NFLAG-1:0] set_ev;
    logic push, first, flush, uf_hit;

    always_comb begin
        logic [CW-1:0] cnt_nx;
        fs_d   = fs_q;
        set_ev = '0;
        push   = 1'b0;
        first  = 1'b0;
        uf_hit = 1'b0;
        cnt_nx = fs_q.cnt;
        if (byte_vld) begin
            if (fs_q.crc_seen) begin
                set_ev[FLG_OVF] = 1'b1;
                fs_d.ovf_frm    = 1'b1;
            end else begin
                push   = 1'b1;
                first  = !fs_q.in_frm;
                cnt_nx = first ? CW'(1) : fs_q.cnt + 1'b1;
                fs_d.cnt = cnt_nx;
                if (first) fs_d.ovf_frm = 1'b0;
                if (wl_thresh != '0 && cnt_nx == {1'b0, wl_thresh})
                    set_ev[FLG_WL] = 1'b1;
            end
            if (!fs_q.in_frm) fs_d.rdy = 1'b0;
            fs_d.in_frm = 1'b1;
        end
        if (crc_good) fs_d.crc_seen = 1'b1;
        if (frm_end && !byte_vld) begin
            uf_hit = !native_mode && (fs_q.cnt < {1'b0, hdr_len});
            set_ev[FLG_EOR] = !uf_hit;
            set_ev[FLG_UF]  = uf_hit;
            fs_d.rdy      = !uf_hit && !fs_q.ovf_frm;
            fs_d.in_frm   = 1'b0;
            fs_d.crc_seen = 1'b0;
            fs_d.ovf_frm  = 1'b0;
            fs_d.cnt      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign flush     = frm_end && !byte_vld;
    assign buf_ready = fs_q.rdy;

    rxfrm_packer #(.WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .first  (first),
        .dat    (byte_dat),
        .flush  (flush),
        .wr_vld (wr_vld),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    rxfrm_flags #(.NF(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_ev),
        .clr   (flg_clr),
        .en    (flg_en),
        .status(flg_status),
        .irq   (irq)
    );

    assert_uf_no_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && uf_hit) |=> !buf_ready);

    assert_ready_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_ready) |-> $past(frm_end));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_status[FLG_OVF] && !flg_clr[FLG_OVF]) |=> flg_status[FLG_OVF]);

    assert_native_no_uf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (native_mode && !flg_status[FLG_UF]) |=> !flg_status[FLG_UF]);
endmodule

// File: tb/sim_rxfrm_evt_mgr.sv
`timescale 1ns/1ps
module sim_rxfrm_evt_mgr;
    localparam int WB = 4;
    localparam int AW = 6;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_vld = 0, frm_end = 0, crc_good = 0, native_mode = 0;
    logic [7:0] byte_dat = '0;
    logic [LW-1:0] hdr_len = '0, wl_thresh = '0;
    logic [3:0] flg_clr = '0, flg_en = '0;
    logic wr_vld, buf_ready, irq;
    logic [AW-1:0] wr_addr;
    logic [8*WB-1:0] wr_data;
    logic [3:0] flg_status;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rxfrm_evt_mgr #(.WORD_BYTES(WB), .ADDR_W(AW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .frm_end(frm_end), .crc_good(crc_good), .hdr_len(hdr_len),
        .native_mode(native_mode), .wl_thresh(wl_thresh), .flg_clr(flg_clr),
        .flg_en(flg_en), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .flg_status(flg_status), .buf_ready(buf_ready), .irq(irq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_frame(int n, int hdr, bit nat, int wl, int crc_idx, int extra,
                             logic [3:0] en, int seed);
        int acc = 0;
        bit ovf = 0;
        bit uf;
        bit took;
        logic [31:0] ew = '0;
        logic [7:0] b;
        logic [3:0] es;
        native_mode = nat;
        hdr_len = LW'(hdr);
        wl_thresh = LW'(wl);
        flg_en = en;
        flg_clr = 4'hF;
        step();
        flg_clr = 4'h0;
        chk("R9 clear all", 64'(flg_status), 64'h0);
        for (int i = 0; i < n + extra; i++) begin
            b = 8'(seed + i * 37);
            byte_vld = 1'b1;
            byte_dat = b;
            crc_good = (i == crc_idx);
            step();
            took = !(crc_idx >= 0 && i > crc_idx);
            if (!took) ovf = 1'b1;
            else begin
                ew[8*(acc%WB) +: 8] = b;
                acc++;
            end
            if (i == 0) chk("R8 ready drops on new frame", 64'(buf_ready), 64'h0);
            if (took && acc % WB == 0) begin
                chk("R1 word write", 64'(wr_vld), 64'h1);
                chk("R1 word addr", 64'(wr_addr), 64'(acc / WB - 1));
                chk("R1 word data", 64'(wr_data), 64'(ew));
                ew = '0;
            end else begin
                chk(took ? "R1 no write" : "R7 excess not stored", 64'(wr_vld), 64'h0);
            end
            chk("R4 waterlevel", 64'(flg_status[1]), 64'(wl != 0 && acc >= wl));
            chk("R7 overflow flag", 64'(flg_status[3]), 64'(ovf));
        end
        byte_vld = 1'b0;
        crc_good = 1'b0;
        frm_end = 1'b1;
        step();
        frm_end = 1'b0;
        uf = !nat && acc < hdr;
        if (acc % WB != 0) begin
            chk("R2 flush write", 64'(wr_vld), 64'h1);
            chk("R2 flush addr", 64'(wr_addr), 64'(acc / WB));
            chk("R2 flush data", 64'(wr_data), 64'(ew));
        end else begin
            chk("R2 no flush", 64'(wr_vld), 64'h0);
        end
        es = {ovf, uf, (wl != 0 && acc >= wl), !uf};
        chk("R3 end flag", 64'(flg_status[0]), 64'(!uf));
        chk(nat ? "R6 native no underflow" : "R5 underflow", 64'(flg_status[2]), 64'(uf));
        chk("R8 ready", 64'(buf_ready), 64'(!uf && !ovf));
        chk("R10 irq", 64'(irq), 64'(|(es & en)));
        step();
        chk("R8 ready holds", 64'(buf_ready), 64'(!uf && !ovf));
        chk("R7 overflow sticky", 64'(flg_status[3]), 64'(ovf));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed = 1;
        int hdrs[3];
        int wls[4];
        #1;
        chk("R11 reset flags", 64'(flg_status), 64'h0);
        chk("R11 reset ready", 64'(buf_ready), 64'h0);
        chk("R11 reset irq", 64'(irq), 64'h0);
        chk("R11 reset write", 64'(wr_vld), 64'h0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        for (int n = 1; n <= 9; n++) begin
            hdrs = '{n - 1, n, n + 2};
            wls = '{0, 1, n, n + 1};
            for (int h = 0; h < 3; h++)
                for (int nat = 0; nat < 2; nat++)
                    for (int w = 0; w < 4; w++)
                        for (int c = 0; c < 2; c++) begin
                            run_frame(n, hdrs[h], nat[0], wls[w], c ? n - 1 : -1,
                                      c ? 2 : 0, 4'(seed * 5 + 3), seed);
                            seed++;
                        end
        end
        // R9: clear colliding with a waterlevel set leaves the flag set
        wl_thresh = 8'd1;
        native_mode = 1'b1;
        flg_en = 4'b0010;
        flg_clr = 4'hF;
        step();
        byte_vld = 1'b1;
        byte_dat = 8'hA5;
        flg_clr = 4'b0010;
        step();
        byte_vld = 1'b0;
        flg_clr = 4'h0;
        chk("R9 set wins over clear", 64'(flg_status[1]), 64'h1);
        chk("R10 irq enabled bit", 64'(irq), 64'h1);
        flg_en = 4'b0001;
        #1;
        chk("R10 irq masked", 64'(irq), 64'h0);
        flg_clr = 4'b0010;
        step();
        flg_clr = 4'h0;
        chk("R9 single clear", 64'(flg_status[1]), 64'h0);
        frm_end = 1'b1;
        step();
        frm_end = 1'b0;
        chk("R6 native short frame ends good", 64'(buf_ready), 64'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule